// File: doc/BRIEF.md
# ADC Conversion Sequencer and Interrupt Timer

This block produces the cycle-exact timing of a four-slot conversion sequence for a single sample-and-hold stage and converter. A one-cycle compare-match pulse from a PWM timer starts a sequence. After a fixed two-cycle latency, the block visits the slots strictly in order 0, 1, 2, 3. For each slot it opens a sample window and then runs a fixed 21-cycle conversion. Each slot selects its own input channel, and one acquisition setting applies to every slot.

At the end of each conversion, the block raises a one-cycle end-of-conversion bit for that slot and latches the result into the slot's own register. A single interrupt pulse is tied to one chosen slot. In early placement it fires on the last cycle of that slot's sample window. In late placement it fires on the cycle the slot's end-of-conversion flag pulses. A converter stub stands in for the analog part: it returns a result word computed from the selected channel. A busy flag covers the whole sequence. A trigger that arrives while busy is dropped and recorded in a sticky overflow flag.

Top module: `adc_seq_timer`

## Requirements
- R1: Cycle 1 is the first cycle after the clock edge that samples the trigger. `sample_o` stays low in cycles 1 and 2 and rises in cycle 3.
- R2: Every sample window keeps `sample_o` high for exactly `acq_i`+1 consecutive cycles.
- R3: Each conversion keeps `conv_o` high for exactly 21 cycles. `eoc_o[k]` (bit k for slot k) pulses high for one cycle, on the last conversion cycle of slot k. At most one `eoc_o` bit is high at a time.
- R4: Slots run in order 0 to 3. With period P = `acq_i`+22, slot k's sample window starts in cycle 3+k·P. `sample_o` and `conv_o` are never high together.
- R5: `chsel_i[4k+3:4k]` is slot k's channel, and several slots may share a channel. From the cycle after `eoc_o[k]` pulses, `result_o[12k+11:12k]` holds (channel·257+5) mod 4096.
- R6: With `int_late_i`=1, `int_o` pulses in the cycle that `eoc_o[int_slot_i]` pulses, which is cycle 2+(s+1)·P. For `acq_i`=7 and slot 3, this is cycle 118.
- R7: With `int_late_i`=0, `int_o` pulses in the last sample cycle of slot `int_slot_i`, which is cycle 2+s·P+`acq_i`+1.
- R8: `int_o` is a single-cycle pulse and occurs exactly once per sequence.
- R9: `busy_o` is high from cycle 1 through cycle 2+4·P and low in the cycle after that.
- R10: A trigger sampled while `busy_o` is high sets `ovf_o` and is otherwise ignored: the running sequence keeps its timing and does not restart. A pulse on `ovf_clr_i` clears `ovf_o`. If a set and a clear arrive on the same edge, the set wins.
- R11: After reset, `busy_o`, `sample_o`, `conv_o`, `eoc_o`, `int_o` and `ovf_o` are low and every result register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Compare-match start pulse |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| acq_i | input | 6 | Acquisition setting; window length is this value plus one |
| chsel_i | input | 16 | Channel per slot, 4 bits each, slot 0 in the low bits |
| int_slot_i | input | 2 | Slot whose event drives the interrupt |
| int_late_i | input | 1 | 1: interrupt at end of conversion; 0: at end of sample window |
| ch_o | output | 4 | Channel of the active slot, to the input mux |
| sample_o | output | 1 | Sample-and-hold window strobe |
| conv_o | output | 1 | Conversion strobe |
| eoc_o | output | 4 | One-cycle end-of-conversion pulse, one bit per slot |
| int_o | output | 1 | One-cycle interrupt pulse |
| busy_o | output | 1 | Sequence in progress |
| ovf_o | output | 1 | Sticky trigger-overflow flag |
| result_o | output | 48 | Per-slot result registers, slot 0 in the low bits |

## Verification
The checker watches local relations on every cycle:
- the two-cycle gap between the start of busy and the first sample window;
- the length of every sample window and every conversion, measured with counters;
- mutual exclusion of the sample and conversion strobes;
- one-hot end-of-conversion flags;
- interrupt placement against the sample strobe or the chosen end-of-conversion bit;
- the overflow set and clear rules.

Absolute positions need whole sequences from the bench. These cover the 118-cycle interrupt, the start cycle of each later slot, the result value in each register, exactly one interrupt per run, and a sequence that ignores a stray trigger.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LAT  = 2'd1,
        PH_SAMP = 2'd2,
        PH_CONV = 2'd3
    } phase_e;

    localparam int TRIG_LAT = 2;
endpackage

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
    parameter int CH_W    = 4,
    parameter int RES_W   = 12,
    parameter int RES_MUL = 257,
    parameter int RES_OFS = 5
) (
    input  logic [CH_W-1:0]  ch_i,
    output logic [RES_W-1:0] data_o
);
    // Stand-in for the analog converter: word derived from the channel.
    always_comb begin
        data_o = RES_W'(int'(ch_i) * RES_MUL + RES_OFS);
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NUM_SLOTS = 4,
    parameter int RES_W     = 12
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_SLOTS-1:0]       wr_i,
    input  logic [RES_W-1:0]           data_i,
    output logic [NUM_SLOTS*RES_W-1:0] result_o
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [RES_W-1:0] res_d, res_q;

        always_comb begin
            res_d = wr_i[g] ? data_i : res_q;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) res_q <= '0;
            else         res_q <= res_d;
        end

        assign result_o[g*RES_W +: RES_W] = res_q;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int CH_W        = 4,
    parameter int ACQ_W       = 6,
    parameter int CONV_CYCLES = 21,
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int CONV_W     = $clog2(CONV_CYCLES),
    localparam int CNT_W      = (ACQ_W > CONV_W) ? ACQ_W : CONV_W
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      trig_i,
    input  logic                      ovf_clr_i,
    input  logic [ACQ_W-1:0]          acq_i,
    input  logic [NUM_SLOTS*CH_W-1:0] chsel_i,
    input  logic [SLOT_W-1:0]         int_slot_i,
    input  logic                      int_late_i,
    output logic [CH_W-1:0]           ch_o,
    output logic                      sample_o,
    output logic                      conv_o,
    output logic [NUM_SLOTS-1:0]      eoc_o,
    output logic                      int_o,
    output logic                      busy_o,
    output logic                      ovf_o
);
    localparam logic [CNT_W-1:0]  CONV_LAST = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0]  LAT_LAST  = CNT_W'(TRIG_LAT - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

    typedef struct packed {
        phase_e              phase;
        logic [SLOT_W-1:0]   slot;
        logic [CNT_W-1:0]    cnt;
        logic                ovf;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    samp_end, conv_end;

    always_comb begin
        st_d     = st_q;
        samp_end = (st_q.phase == PH_SAMP) && (st_q.cnt == CNT_W'(acq_i));
        conv_end = (st_q.phase == PH_CONV) && (st_q.cnt == CONV_LAST);

        unique case (st_q.phase)
            PH_IDLE: begin
                if (trig_i) begin
                    st_d.phase = PH_LAT;
                    st_d.slot  = '0;
                    st_d.cnt   = '0;
                end
            end
            PH_LAT: begin
                if (st_q.cnt == LAT_LAST) begin
                    st_d.phase = PH_SAMP;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_SAMP: begin
                if (samp_end) begin
                    st_d.phase = PH_CONV;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_CONV: begin
                if (conv_end) begin
                    st_d.cnt = '0;
                    if (st_q.slot == SLOT_LAST) begin
                        st_d.phase = PH_IDLE;
                        st_d.slot  = '0;
                    end else begin
                        st_d.phase = PH_SAMP;
                        st_d.slot  = st_q.slot + 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase

        // Overflow: a trigger while running is dropped; set beats clear.
        if (trig_i && (st_q.phase != PH_IDLE)) st_d.ovf = 1'b1;
        else if (ovf_clr_i)                    st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= PH_IDLE;
            st_q.slot  <= '0;
            st_q.cnt   <= '0;
            st_q.ovf   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_eoc
        assign eoc_o[g] = conv_end && (st_q.slot == SLOT_W'(g));
    end

    assign ch_o     = chsel_i[st_q.slot*CH_W +: CH_W];
    assign sample_o = (st_q.phase == PH_SAMP);
    assign conv_o   = (st_q.phase == PH_CONV);
    assign busy_o   = (st_q.phase != PH_IDLE);
    assign ovf_o    = st_q.ovf;
    assign int_o    = (st_q.slot == int_slot_i) && (int_late_i ? conv_end : samp_end);
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int NUM_SLOTS   = 4,
    parameter int CH_W        = 4,
    parameter int ACQ_W       = 6,
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 21,
    localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       trig_i,
    input  logic                       ovf_clr_i,
    input  logic [ACQ_W-1:0]           acq_i,
    input  logic [NUM_SLOTS*CH_W-1:0]  chsel_i,
    input  logic [SLOT_W-1:0]          int_slot_i,
    input  logic                       int_late_i,
    output logic [CH_W-1:0]            ch_o,
    output logic                       sample_o,
    output logic                       conv_o,
    output logic [NUM_SLOTS-1:0]       eoc_o,
    output logic                       int_o,
    output logic                       busy_o,
    output logic                       ovf_o,
    output logic [NUM_SLOTS*RES_W-1:0] result_o
);
    logic [RES_W-1:0] conv_data;

    adc_seq_ctrl #(
        .NUM_SLOTS  (NUM_SLOTS),
        .CH_W       (CH_W),
        .ACQ_W      (ACQ_W),
        .CONV_CYCLES(CONV_CYCLES)
    ) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .trig_i    (trig_i),
        .ovf_clr_i (ovf_clr_i),
        .acq_i     (acq_i),
        .chsel_i   (chsel_i),
        .int_slot_i(int_slot_i),
        .int_late_i(int_late_i),
        .ch_o      (ch_o),
        .sample_o  (sample_o),
        .conv_o    (conv_o),
        .eoc_o     (eoc_o),
        .int_o     (int_o),
        .busy_o    (busy_o),
        .ovf_o     (ovf_o)
    );

    adc_conv_stub #(
        .CH_W (CH_W),
        .RES_W(RES_W)
    ) u_stub (
        .ch_i  (ch_o),
        .data_o(conv_data)
    );

    adc_result_bank #(
        .NUM_SLOTS(NUM_SLOTS),
        .RES_W    (RES_W)
    ) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (eoc_o),
        .data_i  (conv_data),
        .result_o(result_o)
    );
endmodule

// File: rtl/adc_seq_timer_chk.sv
module adc_seq_timer_chk #(
    parameter int NUM_SLOTS   = 4,
    parameter int ACQ_W       = 6,
    parameter int CONV_CYCLES = 21,
    localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 trig_i,
    input logic                 ovf_clr_i,
    input logic [ACQ_W-1:0]     acq_i,
    input logic [SLOT_W-1:0]    int_slot_i,
    input logic                 int_late_i,
    input logic                 sample_o,
    input logic                 conv_o,
    input logic [NUM_SLOTS-1:0] eoc_o,
    input logic                 int_o,
    input logic                 busy_o,
    input logic                 ovf_o
);
    logic [15:0] samp_len, conv_len;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            samp_len <= '0;
            conv_len <= '0;
        end else begin
            samp_len <= sample_o ? samp_len + 16'd1 : 16'd0;
            conv_len <= conv_o   ? conv_len + 16'd1 : 16'd0;
        end
    end

    assert_first_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> !sample_o ##1 !sample_o ##1 sample_o);

    assert_busy_needs_trig_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(trig_i));

    assert_window_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sample_o) |-> int'(samp_len) == int'(acq_i) + 1);

    assert_conv_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(conv_o) |-> int'(conv_len) == CONV_CYCLES);

    assert_eoc_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(eoc_o));

    assert_eoc_in_conv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoc_o != '0) |-> conv_o ##1 !conv_o);

    assert_no_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sample_o && conv_o));

    assert_late_int_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int_o && int_late_i) |-> eoc_o[int_slot_i]);

    assert_early_int_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int_o && !int_late_i) |-> sample_o ##1 !sample_o);

    assert_int_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_o |=> !int_o);

    assert_busy_strobes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_o || conv_o) |-> busy_o);

    assert_ovf_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_i && busy_o) |=> ovf_o);

    assert_ovf_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_clr_i && !(trig_i && busy_o)) |=> !ovf_o);

    assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !ovf_clr_i) |=> ovf_o);
endmodule

bind adc_seq_timer adc_seq_timer_chk #(
    .NUM_SLOTS  (NUM_SLOTS),
    .ACQ_W      (ACQ_W),
    .CONV_CYCLES(CONV_CYCLES)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .ovf_clr_i (ovf_clr_i),
    .acq_i     (acq_i),
    .int_slot_i(int_slot_i),
    .int_late_i(int_late_i),
    .sample_o  (sample_o),
    .conv_o    (conv_o),
    .eoc_o     (eoc_o),
    .int_o     (int_o),
    .busy_o    (busy_o),
    .ovf_o     (ovf_o)
);

// File: tb/adc_seq_timer_tb.sv
module adc_seq_timer_tb;
    localparam int NS    = 4;
    localparam int CH_W  = 4;
    localparam int ACQ_W = 6;
    localparam int RES_W = 12;
    localparam int CONV  = 21;

    // Vector: [31:24] acq, [23:20] interrupt slot, [19:16] late, [15:0] channels (slot 0 low)
    localparam int NV = 5;
    localparam logic [31:0] VEC [NV] = '{
        32'h0731_4321,
        32'h0730_2211,
        32'h0001_F0A5,
        32'h0210_7777,
        32'h3F21_0C3E
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                   rst_n, trig, clr, late;
    logic [ACQ_W-1:0]       acq;
    logic [NS*CH_W-1:0]     chsel;
    logic [1:0]             islot;
    logic [CH_W-1:0]        ch;
    logic                   samp, conv, intr, busy, ovf;
    logic [NS-1:0]          eoc;
    logic [NS*RES_W-1:0]    res;

    adc_seq_timer u_dut (
        .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .ovf_clr_i(clr),
        .acq_i(acq), .chsel_i(chsel), .int_slot_i(islot), .int_late_i(late),
        .ch_o(ch), .sample_o(samp), .conv_o(conv), .eoc_o(eoc), .int_o(intr),
        .busy_o(busy), .ovf_o(ovf), .result_o(res)
    );

    int errors = 0;
    int checks = 0;

    int s_start [NS];
    int eoc_at  [NS];
    int eoc_cnt, int_at, int_cnt, busy_end, samp_cyc, conv_cyc, n_starts;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int res_of(input int c);
        return (c * 257 + 5) % 4096;
    endfunction

    task automatic run_seq(input int mid_n, input bit mid_clr);
        bit prev = 1'b0;
        for (int k = 0; k < NS; k++) begin s_start[k] = 0; eoc_at[k] = 0; end
        eoc_cnt = 0; int_at = 0; int_cnt = 0; busy_end = 0;
        samp_cyc = 0; conv_cyc = 0; n_starts = 0;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        for (int n = 1; n < 1000; n++) begin
            if (samp && !prev) begin
                if (n_starts < NS) s_start[n_starts] = n;
                n_starts++;
            end
            prev = samp;
            if (samp) samp_cyc++;
            if (conv) conv_cyc++;
            for (int k = 0; k < NS; k++) if (eoc[k]) begin eoc_at[k] = n; eoc_cnt++; end
            if (intr) begin int_at = n; int_cnt++; end
            if (!busy) begin busy_end = n; break; end
            trig = (n == mid_n);
            clr  = (n == mid_n) && mid_clr;
            @(negedge clk);
        end
        trig = 1'b0;
        clr  = 1'b0;
    endtask

    task automatic check_seq(input int s, input bit lt);
        int p = int'(acq) + 1 + CONV;
        int exp_int = lt ? 2 + (s + 1) * p : 2 + s * p + int'(acq) + 1;
        chk("R1 first window start", s_start[0], 3);
        for (int k = 1; k < NS; k++) chk("R4 slot window start", s_start[k], 3 + k * p);
        chk("R4 window count", n_starts, NS);
        chk("R2 sample cycles", samp_cyc, NS * (int'(acq) + 1));
        chk("R3 conversion cycles", conv_cyc, NS * CONV);
        for (int k = 0; k < NS; k++) chk("R3 eoc cycle", eoc_at[k], 2 + (k + 1) * p);
        chk("R3 eoc pulses", eoc_cnt, NS);
        chk(lt ? "R6 late interrupt cycle" : "R7 early interrupt cycle", int_at, exp_int);
        chk("R8 interrupt count", int_cnt, 1);
        chk("R9 busy end", busy_end, 3 + NS * p);
        for (int k = 0; k < NS; k++)
            chk("R5 result", int'(res[k*RES_W +: RES_W]), res_of(int'(chsel[k*CH_W +: CH_W])));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; trig = 1'b0; clr = 1'b0; late = 1'b1;
        acq = '0; chsel = '0; islot = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk("R11 busy", int'(busy), 0);
        chk("R11 sample/conv", int'(samp | conv), 0);
        chk("R11 eoc/int", int'(eoc) + int'(intr), 0);
        chk("R11 ovf", int'(ovf), 0);
        chk("R11 results", int'(res != '0), 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            acq   = ACQ_W'(VEC[v][31:24]);
            islot = VEC[v][21:20];
            late  = VEC[v][16];
            chsel = VEC[v][15:0];
            run_seq(-1, 1'b0);
            check_seq(int'(islot), late);
            chk("R10 idle trigger leaves ovf low", int'(ovf), 0);
            @(negedge clk);
        end

        // R6 headline: acq 7, slot 3, late -> cycle 118
        acq = 6'd7; islot = 2'd3; late = 1'b1; chsel = 16'h1111;
        run_seq(-1, 1'b0);
        chk("R6 interrupt at 118", int_at, 118);
        chk("R5 shared channel slot3", int'(res[3*RES_W +: RES_W]), res_of(1));

        // R10: stray trigger mid-sequence is ignored and flagged
        run_seq(50, 1'b0);
        chk("R10 ovf set", int'(ovf), 1);
        chk("R10 timing unchanged int", int_at, 118);
        chk("R10 no restart busy end", busy_end, 119);
        chk("R10 no restart window count", n_starts, NS);
        @(negedge clk);
        chk("R10 ovf sticky", int'(ovf), 1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R10 ovf cleared", int'(ovf), 0);

        // R10: trigger on last busy cycle together with clear -> set wins, no restart
        run_seq(118, 1'b1);
        chk("R10 set beats clear", int'(ovf), 1);
        chk("R10 last-cycle trigger busy end", busy_end, 119);
        repeat (3) @(negedge clk);
        chk("R10 stays idle", int'(busy), 0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R10 ovf cleared again", int'(ovf), 0);

        finish_run();
    end
endmodule